// File: doc/BRIEF.md
# Serial FIFO Fill Tracker

This block sits between the data register of a serial controller and its two shifters. It holds a small transmit queue and a small receive queue. It reports how many words each queue holds and derives three status flags from those levels. The transmit-empty flag follows a programmable level. The receive-full flag marks a full receive queue. A sticky overflow flag is raised only after the receive side has stayed full and unread for a grace period.

All data moves over valid/ready streams. The register-write stream (`wr_*`) has no back-pressure in the usual sense. `wr_ready` low tells the writer that the queue is full, and a word presented then is dropped rather than held. The shifter side of the transmit queue (`tx_*`) is a normal stream: a word leaves on a cycle where `tx_valid` and `tx_ready` are both high. The receive shifter pushes through `rx_valid` with no ready, since it cannot stall. The register-read stream (`rd_*`) takes a word on `rd_valid && rd_ready`. A read strobe with no word held does nothing.

Clearing `fifo_en` turns each queue into a single-word buffer and forces the effective watermark to zero. Software is expected to change `fifo_en` only while both queues are empty.

Top module: `sfifo_stat`

## Requirements
- R1: After reset both counts are 0, `tx_empty` is 1, `rx_full` and `rx_ovf` are 0, `wr_ready` is 1 and `ctrl_cnt` is 0 (with `tx_wm` held at 0).
- R2: When the transmit queue holds fewer words than its capacity, a word offered on `wr_valid` is accepted and `tx_cnt` rises by one. Each `tx_valid && tx_ready` cycle lowers `tx_cnt` by one. Words leave in the order they were accepted.
- R3: Capacity is 4 words with `fifo_en`=1 and 1 word with `fifo_en`=0. A word offered to a full queue (transmit or receive) is discarded, and the count and stored words are unchanged. `wr_ready` is 0 exactly when the transmit queue is full.
- R4: `tx_empty` is 1 exactly when `tx_cnt` is less than or equal to the effective watermark. With `fifo_en`=1 the effective watermark is `tx_wm`, a 2-bit value from 0 to 3.
- R5: With `fifo_en`=0 the effective watermark is 0, so `tx_empty` is 1 only when `tx_cnt` is 0.
- R6: Each accepted `rx_valid` raises `rx_cnt` by one. Each `rd_valid && rd_ready` cycle lowers it by one. Words are read back in arrival order.
- R7: `rx_full` is 1 exactly when `rx_cnt` equals the capacity.
- R8: A `word_tick` seen while the receive queue is full and unread arms the grace window; it does not set `rx_ovf`. `rx_ovf` is set by a later `word_tick`, or by a push, while the queue is still full, armed and not read that cycle. A read from a full queue disarms the window.
- R9: `rx_ovf` stays 1 until a cycle with `ovf_clr`=1, which returns it to 0.
- R10: An accepted push and a pop of the same queue in one cycle leave its count unchanged, and the order is kept.
- R11: `ctrl_cnt` bits 15..13 carry `tx_cnt`, bits 12..11 the effective watermark, bits 10..8 `rx_cnt`, and bits 7..0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 4-word queues; 0: single-word buffers |
| tx_wm | input | 2 | Transmit-empty watermark |
| wr_valid | input | 1 | Data-register write strobe |
| wr_ready | output | 1 | Transmit queue has space |
| wr_data | input | DW | Word written |
| tx_valid | output | 1 | Transmit queue holds a word |
| tx_ready | input | 1 | Transmit shifter pops a word |
| tx_data | output | DW | Oldest transmit word |
| rx_valid | input | 1 | Receive shifter pushes a word |
| rx_data | input | DW | Received word |
| rd_valid | output | 1 | Receive queue holds a word |
| rd_ready | input | 1 | Data-register read strobe |
| rd_data | output | DW | Oldest received word |
| word_tick | input | 1 | One pulse per serial word time |
| ovf_clr | input | 1 | Clears the overflow flag |
| tx_cnt | output | CW | Transmit word count |
| rx_cnt | output | CW | Receive word count |
| ctrl_cnt | output | 2*CW+10 | Packed count and watermark fields |
| tx_empty | output | 1 | Transmit level at or below watermark |
| rx_full | output | 1 | Receive queue full |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
A count that drifts from the true occupancy shows at the ports on the next clock edge. It appears as a wrong `tx_cnt`/`rx_cnt` field in `ctrl_cnt`, a misplaced `wr_ready` edge, or a flag out of line with the watermark. A pointer that slips shows only when the affected word leaves, as a data mismatch on the stream the scoreboard watches. A grace-window fault shows one word tick early or late as a change in `rx_ovf`. The bench therefore steps through the window one tick at a time.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int WM_W = 2;
  typedef logic [WM_W-1:0] wm_t;
endpackage

// File: rtl/sfifo_buf.sv
module sfifo_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] cnt,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full     = (cnt >= cap);
  assign push_ok  = push && !full;
  assign pop_ok   = pop && (cnt != '0);
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
      else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == $past(cnt))); // R3
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && cnt != '0) |=> (cnt == $past(cnt))); // R10
endmodule

// File: rtl/sfifo_ovf.sv
module sfifo_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  input  logic rd_pop,
  input  logic push,
  input  logic word_tick,
  input  logic clr,
  output logic ovf
);
  logic armed, hold, set_ovf;

  assign hold    = full && !rd_pop;
  assign set_ovf = hold && armed && (word_tick || push);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      armed <= hold && (armed || word_tick);
      if (clr)          ovf <= 1'b0;
      else if (set_ovf) ovf <= 1'b1;
    end
  end

  AST_OVF_GRACE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(armed)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf); // R9
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ovf); // R9
endmodule

// File: rtl/sfifo_stat.sv
module sfifo_stat #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [1:0]        tx_wm,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DW-1:0]     wr_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DW-1:0]     rd_data,
  input  logic              word_tick,
  input  logic              ovf_clr,
  output logic [CW-1:0]     tx_cnt,
  output logic [CW-1:0]     rx_cnt,
  output logic [2*CW+9:0]   ctrl_cnt,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_ovf
);
  import sfifo_pkg::*;

  wm_t           wm_eff;
  logic [CW-1:0] cap;
  logic          tx_full, rd_pop;

  assign wm_eff = fifo_en ? wm_t'(tx_wm) : '0;
  assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);

  sfifo_buf #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_txq (
    .clk(clk), .rst_n(rst_n), .cap(cap),
    .push(wr_valid), .push_data(wr_data),
    .pop(tx_ready), .pop_data(tx_data),
    .cnt(tx_cnt), .full(tx_full)
  );

  sfifo_buf #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .cap(cap),
    .push(rx_valid), .push_data(rx_data),
    .pop(rd_ready), .pop_data(rd_data),
    .cnt(rx_cnt), .full(rx_full)
  );

  assign rd_pop = rd_ready && rd_valid;

  sfifo_ovf u_ovf (
    .clk(clk), .rst_n(rst_n), .full(rx_full), .rd_pop(rd_pop),
    .push(rx_valid), .word_tick(word_tick), .clr(ovf_clr), .ovf(rx_ovf)
  );

  assign wr_ready = !tx_full;
  assign tx_valid = (tx_cnt != '0);
  assign rd_valid = (rx_cnt != '0);
  assign tx_empty = (tx_cnt <= CW'(wm_eff));
  assign ctrl_cnt = {tx_cnt, wm_eff, rx_cnt, 8'h00};

  AST_TXE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(DEPTH)) |-> !tx_empty); // R4
  AST_TXE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && tx_cnt != '0) |-> !tx_empty); // R5
  AST_RXF_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_cnt == CW'(DEPTH)) |-> rx_full); // R7
  AST_WR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && tx_cnt < CW'(DEPTH)) |-> wr_ready); // R3
endmodule

// File: tb/test_sfifo_stat.sv
module test_sfifo_stat;
  localparam int PERIOD = 10;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0, fifo_en = 1;
  logic [1:0] tx_wm = 0;
  logic wr_valid = 0, tx_ready = 0, rx_valid = 0, rd_ready = 0;
  logic word_tick = 0, ovf_clr = 0;
  logic [DW-1:0] wr_data = 0, rx_data = 0;
  logic wr_ready, tx_valid, rd_valid, tx_empty, rx_full, rx_ovf;
  logic [DW-1:0] tx_data, rd_data;
  logic [2:0] tx_cnt, rx_cnt;
  logic [15:0] ctrl_cnt;

  int checks = 0, fails = 0;
  int tx_m = 0, rx_m = 0;
  logic [DW-1:0] txq[$], rxq[$];

  always #(PERIOD/2) clk = ~clk;

  sfifo_stat i_sfifo_stat (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_wm(tx_wm),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .word_tick(word_tick), .ovf_clr(ovf_clr),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ctrl_cnt(ctrl_cnt),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares words leaving either queue against the scoreboard
  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      checks++;
      if (txq.size() == 0) begin
        fails++; $display("FAIL R2: actual %0h expected none", tx_data);
      end else begin
        logic [DW-1:0] e;
        e = txq.pop_front();
        if (tx_data !== e) begin
          fails++; $display("FAIL R2: actual %0h expected %0h", tx_data, e);
        end
      end
    end
    if (rst_n && rd_valid && rd_ready) begin
      checks++;
      if (rxq.size() == 0) begin
        fails++; $display("FAIL R6: actual %0h expected none", rd_data);
      end else begin
        logic [DW-1:0] e;
        e = rxq.pop_front();
        if (rd_data !== e) begin
          fails++; $display("FAIL R6: actual %0h expected %0h", rd_data, e);
        end
      end
    end
  end

  // driver: applies the strobes set by the caller for one clock
  task automatic cyc();
    int cap;
    bit ta, tp, ra, rp;
    cap = fifo_en ? 4 : 1;
    ta = wr_valid && tx_m < cap;
    tp = tx_ready && tx_m > 0;
    ra = rx_valid && rx_m < cap;
    rp = rd_ready && rx_m > 0;
    if (ta) txq.push_back(wr_data);
    if (ra) rxq.push_back(rx_data);
    tx_m = tx_m + int'(ta) - int'(tp);
    rx_m = rx_m + int'(ra) - int'(rp);
    @(negedge clk);
    wr_valid = 0; tx_ready = 0; rx_valid = 0; rd_ready = 0;
    word_tick = 0; ovf_clr = 0;
  endtask

  task automatic wr(logic [DW-1:0] d);
    wr_valid = 1; wr_data = d; cyc();
  endtask

  task automatic rxp(logic [DW-1:0] d);
    rx_valid = 1; rx_data = d; cyc();
  endtask

  initial begin
    #(PERIOD*200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 tx_cnt", tx_cnt, 0);
    chk("R1 rx_cnt", rx_cnt, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 rx_ovf", rx_ovf, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 ctrl", ctrl_cnt, 0);

    // transmit fill with watermark 1 (R2, R4)
    tx_wm = 2'd1;
    wr(16'hA001);
    chk("R2 tx_cnt", tx_cnt, 1);
    chk("R4 empty at 1<=1", tx_empty, 1);
    wr(16'hA002);
    chk("R4 empty at 2>1", tx_empty, 0);
    chk("R11 ctrl", ctrl_cnt, 16'h4800);
    tx_wm = 2'd3;
    #1 chk("R4 empty at 2<=3", tx_empty, 1);
    wr(16'hA003);
    wr(16'hA004);
    chk("R2 tx_cnt full", tx_cnt, 4);
    chk("R3 wr_ready low", wr_ready, 0);
    chk("R4 empty at 4", tx_empty, 0);
    wr(16'hDEAD);
    chk("R3 dropped write", tx_cnt, 4);
    // drain two, then push+pop together (R10)
    tx_ready = 1; cyc();
    tx_ready = 1; cyc();
    chk("R2 tx_cnt after pops", tx_cnt, 2);
    wr_valid = 1; wr_data = 16'hA005; tx_ready = 1; cyc();
    chk("R10 tx same cycle", tx_cnt, 2);
    repeat (3) begin tx_ready = 1; cyc(); end
    chk("R2 tx drained", tx_cnt, 0);
    chk("R2 scoreboard empty", txq.size(), 0);

    // disabled mode (R5, R3)
    fifo_en = 0; tx_wm = 2'd3;
    #1 chk("R11 wm field forced", ctrl_cnt, 16'h0000);
    wr(16'hB001);
    chk("R5 tx_cnt single", tx_cnt, 1);
    chk("R5 empty off", tx_empty, 0);
    chk("R3 single full", wr_ready, 0);
    wr(16'hB002);
    chk("R3 single drop", tx_cnt, 1);
    tx_ready = 1; cyc();
    chk("R5 empty when 0", tx_empty, 1);
    rxp(16'hC001);
    chk("R7 single rx full", rx_full, 1);
    rd_ready = 1; cyc();
    chk("R6 single read", rx_cnt, 0);
    fifo_en = 1; tx_wm = 2'd0;

    // receive fill and overflow grace (R6, R7, R8, R9)
    rxp(16'hD001); rxp(16'hD002); rxp(16'hD003);
    chk("R7 not full at 3", rx_full, 0);
    rxp(16'hD004);
    chk("R6 rx_cnt", rx_cnt, 4);
    chk("R7 full at 4", rx_full, 1);
    chk("R11 rx field", ctrl_cnt, 16'h0400);
    word_tick = 1; cyc();
    chk("R8 first tick no ovf", rx_ovf, 0);
    rd_ready = 1; cyc();
    chk("R6 read lowers", rx_cnt, 3);
    chk("R7 full drops", rx_full, 0);
    rxp(16'hD005);
    word_tick = 1; cyc();
    chk("R8 rearm no ovf", rx_ovf, 0);
    word_tick = 1; cyc();
    chk("R8 ovf after grace", rx_ovf, 1);
    cyc();
    chk("R9 sticky", rx_ovf, 1);
    ovf_clr = 1; cyc();
    chk("R9 cleared", rx_ovf, 0);
    rxp(16'hEEEE);
    chk("R3 rx drop", rx_cnt, 4);
    chk("R8 push at full armed", rx_ovf, 1);
    ovf_clr = 1; cyc();
    rd_ready = 1; cyc();
    rd_ready = 1; rx_valid = 1; rx_data = 16'hD006; cyc();
    chk("R10 rx same cycle", rx_cnt, 3);
    chk("R8 no ovf after reads", rx_ovf, 0);
    repeat (3) begin rd_ready = 1; cyc(); end
    chk("R6 rx drained", rx_cnt, 0);
    chk("R6 scoreboard empty", rxq.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule